// File: doc/BRIEF.md
# Two-Way Set Associative Lookup with Selectable Replacement

This block is the tag, valid and line storage of a small two-way set associative cache, together with its victim choice. Every set holds two ways. Each way has its own tag, valid flag and 16-byte line. A read request splits the address into a byte offset, a set index and a tag. The block compares the tag against both ways of the indexed set at the same time. One cycle later it returns a hit flag, the way concerned and the addressed byte of the matching line.

On a miss, the response names the way that a refill of that set would overwrite. The refill itself arrives on a separate line-fill port and is written into that way. One status bit per set records which way is the older one. A parameter selects how that bit is kept. In first-in-first-out mode it changes only when a line is loaded. In least-recently-used mode it changes on every hit and every fill.

Top module: `two_way_cache`

## Requirements
- R1: The address splits as offset `addr[OFFS_W-1:0]`, set index `addr[OFFS_W+IDX_W-1:OFFS_W]` and tag taking every remaining upper bit. With the defaults this is offset [3:0], index [9:4] and a 22-bit tag [31:10]. An address that differs from a resident block in any tag bit misses.
- R2: After reset no way is valid and every lookup misses. The first fill of any set goes to way 0.
- R3: `rsp_valid_o` is high exactly in the cycle after a cycle with `rd_req_i` high. On a hit, `rsp_way_o` gives the matching way and `rsp_data_o` is line bits [8*off+7 : 8*off].
- R4: On a miss, `rsp_hit_o` is 0, `rsp_data_o` is 0, and `rsp_way_o` gives the way a fill of that set would take at that moment.
- R5: An invalid way is taken as the victim before the status bit is used. Way 0 is taken if it is invalid, otherwise way 1 if it is invalid.
- R6: When both ways of a set are valid, the victim is the way marked older.
- R7: In FIFO mode a fill marks the other way older, and hits leave the marking unchanged.
- R8: In LRU mode a hit or a fill marks the other way of that set older.
- R9: A missing lookup changes no status bit.
- R10: Two blocks with the same set index but different tags both stay resident while they are read alternately.
- R11: A fill writes tag, line and valid into the victim way of its set only. Other sets are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| rd_req_i | input | 1 | Lookup request |
| rd_addr_i | input | ADDR_W | Lookup byte address |
| rsp_valid_o | output | 1 | Lookup response valid |
| rsp_hit_o | output | 1 | Response is a hit |
| rsp_way_o | output | 1 | Hit way, or victim way on a miss |
| rsp_data_o | output | 8 | Addressed byte on a hit, zero on a miss |
| fill_i | input | 1 | Line fill strobe |
| fill_blk_i | input | ADDR_W-OFFS_W | Line address of the fill (address without offset) |
| fill_line_i | input | 8<<OFFS_W | Line data, byte k at bits [8k+7:8k] |

## Verification
The assertions assume two things about the inputs. A lookup and a fill never occur in the same cycle. A fill never loads a block that is already resident, so at most one way can match. The bench keeps to both. Every request or fill is issued by its own task for one cycle only. Fills target only blocks that the preceding lookup reported as missing. Both replacement modes run side by side on the same stimulus, so the points where FIFO and LRU victims diverge are checked directly against each other's expected ways.

// File: rtl/two_way_cache_pkg.sv
package two_way_cache_pkg;
  typedef enum logic {
    REPL_FIFO = 1'b0,
    REPL_LRU  = 1'b1
  } repl_mode_e;

  localparam int unsigned NUM_WAYS = 2;
endpackage

// File: rtl/cache_way_store.sv
module cache_way_store #(
  parameter int unsigned TAG_W  = 22,
  parameter int unsigned IDX_W  = 6,
  parameter int unsigned LINE_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  idx_i,
  output logic              valid_o,
  output logic [TAG_W-1:0]  tag_o,
  output logic [LINE_W-1:0] line_o,
  input  logic              wr_en_i,
  input  logic [TAG_W-1:0]  wr_tag_i,
  input  logic [LINE_W-1:0] wr_line_i
);
  localparam int unsigned SETS = 1 << IDX_W;

  logic [SETS-1:0]   valid_q;
  logic [TAG_W-1:0]  tag_q  [SETS];
  logic [LINE_W-1:0] line_q [SETS];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= '0;
    else if (wr_en_i) valid_q[idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      tag_q[idx_i]  <= wr_tag_i;
      line_q[idx_i] <= wr_line_i;
    end
  end

  assign valid_o = valid_q[idx_i];
  assign tag_o   = tag_q[idx_i];
  assign line_o  = line_q[idx_i];

  // R11: a written entry reads back valid
  assert_fill_sets_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> valid_q[$past(idx_i)]);
endmodule

// File: rtl/repl_ctrl.sv
module repl_ctrl
  import two_way_cache_pkg::*;
#(
  parameter int unsigned IDX_W = 6,
  parameter repl_mode_e  MODE  = REPL_LRU
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [1:0]       valid_i,
  output logic             victim_o,
  input  logic             fill_i,
  input  logic             hit_i,
  input  logic             hit_way_i
);
  localparam int unsigned SETS = 1 << IDX_W;

  // per set: index of the way that is older / less recently used
  logic [SETS-1:0] old_q;

  always_comb begin
    if (!valid_i[0])      victim_o = 1'b0;
    else if (!valid_i[1]) victim_o = 1'b1;
    else                  victim_o = old_q[idx_i];
  end

  generate
    if (MODE == REPL_LRU) begin : g_lru
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     old_q <= '0;
        else if (fill_i) old_q[idx_i] <= ~victim_o;
        else if (hit_i)  old_q[idx_i] <= ~hit_way_i;
      end
    end else begin : g_fifo
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)     old_q <= '0;
        else if (fill_i) old_q[idx_i] <= ~victim_o;
      end
      // R7: hits leave the age marking alone
      assert_fifo_hit_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (hit_i && !fill_i) |=> old_q == $past(old_q));
    end
  endgenerate

  // R5: a free way is never passed over
  assert_invalid_first_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i != 2'b11) |-> !valid_i[victim_o]);

  // R9: no lookup activity without hit or fill touches the marking
  assert_miss_no_update_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!hit_i && !fill_i) |=> old_q == $past(old_q));
endmodule

// File: rtl/two_way_cache.sv
module two_way_cache
  import two_way_cache_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned OFFS_W = 4,
  parameter int unsigned IDX_W  = 6,
  parameter repl_mode_e  MODE   = REPL_LRU,
  localparam int unsigned LINE_W = 8 << OFFS_W,
  localparam int unsigned BLK_W  = ADDR_W - OFFS_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic              rsp_valid_o,
  output logic              rsp_hit_o,
  output logic              rsp_way_o,
  output logic [7:0]        rsp_data_o,
  input  logic              fill_i,
  input  logic [BLK_W-1:0]  fill_blk_i,
  input  logic [LINE_W-1:0] fill_line_i
);
  localparam int unsigned TAG_W = BLK_W - IDX_W;

  logic [OFFS_W-1:0] rd_off;
  logic [IDX_W-1:0]  rd_idx, fill_idx, lk_idx;
  logic [TAG_W-1:0]  rd_tag, fill_tag;

  assign rd_off   = rd_addr_i[OFFS_W-1:0];
  assign rd_idx   = rd_addr_i[OFFS_W+IDX_W-1:OFFS_W];
  assign rd_tag   = rd_addr_i[ADDR_W-1:OFFS_W+IDX_W];
  assign fill_idx = fill_blk_i[IDX_W-1:0];
  assign fill_tag = fill_blk_i[BLK_W-1:IDX_W];
  assign lk_idx   = fill_i ? fill_idx : rd_idx;

  logic [NUM_WAYS-1:0] way_valid, hit_w, wr_w;
  logic [TAG_W-1:0]    way_tag  [NUM_WAYS];
  logic [LINE_W-1:0]   way_line [NUM_WAYS];
  logic                victim;

  for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
    assign wr_w[w]  = fill_i && (victim == w[0]);
    assign hit_w[w] = rd_req_i && !fill_i && way_valid[w] && (way_tag[w] == rd_tag);

    cache_way_store #(
      .TAG_W (TAG_W),
      .IDX_W (IDX_W),
      .LINE_W(LINE_W)
    ) u_store (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .idx_i    (lk_idx),
      .valid_o  (way_valid[w]),
      .tag_o    (way_tag[w]),
      .line_o   (way_line[w]),
      .wr_en_i  (wr_w[w]),
      .wr_tag_i (fill_tag),
      .wr_line_i(fill_line_i)
    );
  end

  logic hit, hit_way;
  assign hit     = |hit_w;
  assign hit_way = hit_w[1];

  repl_ctrl #(
    .IDX_W(IDX_W),
    .MODE (MODE)
  ) u_repl (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .idx_i    (lk_idx),
    .valid_i  (way_valid),
    .victim_o (victim),
    .fill_i   (fill_i),
    .hit_i    (hit),
    .hit_way_i(hit_way)
  );

  logic [LINE_W-1:0] sel_line;
  logic [7:0]        sel_byte;
  assign sel_line = way_line[hit_way];
  assign sel_byte = hit ? sel_line[{rd_off, 3'b000} +: 8] : 8'h00;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      rsp_hit_o   <= 1'b0;
      rsp_way_o   <= 1'b0;
      rsp_data_o  <= '0;
    end else begin
      rsp_valid_o <= rd_req_i;
      if (rd_req_i) begin
        rsp_hit_o  <= hit;
        rsp_way_o  <= hit ? hit_way : victim;
        rsp_data_o <= sel_byte;
      end
    end
  end

  // input rule: lookup and fill never share a cycle
  assert_no_collision_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(rd_req_i && fill_i));

  assert_rsp_follows_req_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_req_i |=> rsp_valid_o);

  assert_rsp_idle_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_req_i |=> !rsp_valid_o);

  // R10: resident blocks are unique, so at most one way matches
  assert_single_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(hit_w) <= 1);

  assert_miss_zero_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_hit_o) |-> (rsp_data_o == 8'h00));
endmodule

// File: tb/two_way_cache_bench.sv
module two_way_cache_bench;
  import two_way_cache_pkg::*;

  localparam int unsigned ADDR_W = 32;
  localparam int unsigned OFFS_W = 4;
  localparam int unsigned IDX_W  = 6;
  localparam int unsigned LINE_W = 8 << OFFS_W;
  localparam int unsigned BLK_W  = ADDR_W - OFFS_W;
  localparam int unsigned TAG_W  = BLK_W - IDX_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic              rd_req = 1'b0;
  logic [ADDR_W-1:0] rd_addr = '0;
  logic              fill = 1'b0;
  logic [BLK_W-1:0]  fill_blk = '0;
  logic [LINE_W-1:0] fill_line = '0;

  logic       l_valid, l_hit, l_way;
  logic [7:0] l_data;
  logic       f_valid, f_hit, f_way;
  logic [7:0] f_data;

  two_way_cache #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W), .MODE(REPL_LRU)) u_two_way_cache (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rsp_valid_o(l_valid), .rsp_hit_o(l_hit), .rsp_way_o(l_way), .rsp_data_o(l_data),
    .fill_i(fill), .fill_blk_i(fill_blk), .fill_line_i(fill_line));

  two_way_cache #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .IDX_W(IDX_W), .MODE(REPL_FIFO)) u_two_way_cache_fifo (
    .clk_i(clk), .rst_ni(rst_n), .rd_req_i(rd_req), .rd_addr_i(rd_addr),
    .rsp_valid_o(f_valid), .rsp_hit_o(f_hit), .rsp_way_o(f_way), .rsp_data_o(f_data),
    .fill_i(fill), .fill_blk_i(fill_blk), .fill_line_i(fill_line));

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 1'b0;

  function automatic logic [ADDR_W-1:0] mk_addr(input logic [TAG_W-1:0] tag,
                                                 input logic [IDX_W-1:0] idx,
                                                 input logic [OFFS_W-1:0] off);
    return {tag, idx, off};
  endfunction

  // byte k of a line = {tag nibble, k}
  function automatic logic [LINE_W-1:0] mk_line(input logic [3:0] nib);
    logic [LINE_W-1:0] l;
    for (int k = 0; k < (1 << OFFS_W); k++) l[8*k +: 8] = {nib, k[3:0]};
    return l;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    rd_req = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_req = 1'b0;
  endtask

  task automatic do_fill(input logic [ADDR_W-1:0] a);
    @(negedge clk);
    fill = 1'b1; fill_blk = a[ADDR_W-1:OFFS_W]; fill_line = mk_line(a[OFFS_W+IDX_W+3:OFFS_W+IDX_W]);
    @(negedge clk);
    fill = 1'b0;
  endtask

  // read and compare both modes against expected response
  task automatic look(input logic [ADDR_W-1:0] a, input string req,
                      input bit le_hit, input bit le_way, input logic [7:0] le_data,
                      input bit fe_hit, input bit fe_way, input logic [7:0] fe_data);
    do_read(a);
    check(l_valid == 1'b1, req, "lru valid", int'(l_valid), 1);
    check(l_hit == le_hit && l_way == le_way && l_data == le_data, req, "lru hit/way/data",
          int'({l_hit, 3'b0, l_way, l_data}), int'({le_hit, 3'b0, le_way, le_data}));
    check(f_valid == 1'b1, req, "fifo valid", int'(f_valid), 1);
    check(f_hit == fe_hit && f_way == fe_way && f_data == fe_data, req, "fifo hit/way/data",
          int'({f_hit, 3'b0, f_way, f_data}), int'({fe_hit, 3'b0, fe_way, fe_data}));
  endtask

  localparam logic [IDX_W-1:0] S5 = 6'd5;

  task automatic t_reset();
    check(l_valid == 1'b0 && f_valid == 1'b0, "R3", "idle valid after reset", int'({l_valid, f_valid}), 0);
    look(mk_addr(22'd1, S5, 4'd3), "R2", 0, 0, 8'h00, 0, 0, 8'h00);
    @(negedge clk);
    check(l_valid == 1'b0, "R3", "valid drops without request", int'(l_valid), 0);
  endtask

  task automatic t_first_fill();
    do_fill(mk_addr(22'd1, S5, 4'd0));
    look(mk_addr(22'd1, S5, 4'd3),  "R2", 1, 0, 8'h13, 1, 0, 8'h13);
    look(mk_addr(22'd1, S5, 4'd15), "R3", 1, 0, 8'h1f, 1, 0, 8'h1f);
    look(mk_addr(22'd2, S5, 4'd0),  "R5", 0, 1, 8'h00, 0, 1, 8'h00);
    do_fill(mk_addr(22'd2, S5, 4'd0));
    look(mk_addr(22'd2, S5, 4'd0),  "R11", 1, 1, 8'h20, 1, 1, 8'h20);
  endtask

  task automatic t_conflict();
    for (int i = 0; i < 4; i++) begin
      look(mk_addr(22'd1, S5, 4'(i)),     "R10", 1, 0, {4'h1, 4'(i)},     1, 0, {4'h1, 4'(i)});
      look(mk_addr(22'd2, S5, 4'(i + 8)), "R10", 1, 1, {4'h2, 4'(i + 8)}, 1, 1, {4'h2, 4'(i + 8)});
    end
  endtask

  task automatic t_victim();
    // A hit makes way 1 least recent in LRU; FIFO still holds way 0 as older
    look(mk_addr(22'd1, S5, 4'd1), "R8", 1, 0, 8'h11, 1, 0, 8'h11);
    look(mk_addr(22'd3, S5, 4'd0), "R6", 0, 1, 8'h00, 0, 0, 8'h00);
    look(mk_addr(22'd3, S5, 4'd0), "R9", 0, 1, 8'h00, 0, 0, 8'h00);
    do_fill(mk_addr(22'd3, S5, 4'd0));
    look(mk_addr(22'd3, S5, 4'd7), "R7", 1, 1, 8'h37, 1, 0, 8'h37);
    // LRU kept A (way 0); FIFO evicted A, C hit left way 1 marked older
    look(mk_addr(22'd1, S5, 4'd2), "R7", 1, 0, 8'h12, 0, 1, 8'h00);
    look(mk_addr(22'd2, S5, 4'd4), "R8", 0, 1, 8'h00, 1, 1, 8'h24);
  endtask

  task automatic t_fields();
    look(mk_addr(22'd1 | 22'h200000, S5, 4'd0), "R1", 0, 1, 8'h00, 0, 1, 8'h00);
    look(mk_addr(22'd1, 6'd6, 4'd0),            "R11", 0, 0, 8'h00, 0, 0, 8'h00);
    look(mk_addr(22'd1, 6'd37, 4'd0),           "R1", 0, 0, 8'h00, 0, 0, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_first_fill();
    t_conflict();
    t_victim();
    t_fields();
    repeat (2) @(negedge clk);
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    #100000;
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end
endmodule